// File: doc/BRIEF.md
# RTC Alarm Comparator

This block watches the running time of a real-time clock and raises a sticky alarm flag when the time reaches a programmed alarm setting. Software loads four alarm bytes (seconds, minutes, hours, day/date) and a control byte through a simple write port. The timekeeping logic drives the current BCD time together with a one-cycle strobe each time the time advances by a second.

A mask bit in each alarm byte, plus a day/date select bit, chooses the repeat rate. The rates are every second, on a seconds match, on a minutes-and-seconds match, on an hours-minutes-seconds match, and on a full match that adds either the day of the week or the date of the month. Any other mask pattern falls back to firing every second, which makes a bad setting easy to notice.

The flag drives an active-low interrupt and an active-low power-wake output, each gated by its own enable. The flag stays set until the clear input is pulsed.

Top module: `rtc_alarm_match`

## Requirements
- R1: Writes with `wr_en_i` high take effect at the next clock edge. Address 8h holds the seconds alarm, 9h the minutes alarm, Ah the hours alarm and Bh the day/date alarm. Bit 7 of each alarm byte is its mask bit (AM1 for 8h, AM2 for 9h, AM3 for Ah, AM4 for Bh). Address Ch holds the control byte: bit 0 is the transfer enable, bit 1 the interrupt enable and bit 2 the power-wake enable.
- R2: With AM4..AM1 = 1111, every tick sets the flag.
- R3: With AM4..AM1 = 1110, a tick sets the flag only when the seconds match. With 1100, the minutes and seconds must both match. With 1000, the hours, minutes and seconds must all match.
- R4: With AM4..AM1 = 0000, the day/date field must match as well. Bit 6 of the byte at Bh selects the comparison: 0 compares bits 5:0 with `date_i`, and 1 compares them with `wday_i`.
- R5: Every mask pattern not listed in R2 to R4 behaves exactly like 1111 and fires on every tick.
- R6: A match sets the flag only while the transfer enable is 1.
- R7: The flag changes only at a tick or a clear. It stays set until `clr_i` is high at a clock edge. When a setting tick and a clear occur in the same cycle, the flag stays set.
- R8: `irq_no` is low exactly while the flag and the interrupt enable are both 1. `pwr_no` is low exactly while the flag and the power-wake enable are both 1. Both rise in the cycle after the flag clears or after their enable is written to 0.
- R9: Reset clears every alarm byte, every enable and the flag, and holds both `irq_no` and `pwr_no` high.
- R10: Seconds and minutes are compared as 7-bit values and hours as a 6-bit value. Bit 6 of the hours alarm byte is ignored, as are the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | One-cycle pulse when the time advances by one second |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD |
| wday_i | input | 6 | Current day of week |
| date_i | input | 6 | Current date of month, BCD |
| clr_i | input | 1 | Flag clear pulse |
| flag_o | output | 1 | Alarm flag |
| irq_no | output | 1 | Interrupt, active low |
| pwr_no | output | 1 | Power-wake request, active low |

## Verification
The bench builds the block with its default parameters: 7/7/6/6-bit time fields, 8-bit register data, the alarm bytes at 8h to Bh and the control byte at Ch. These values give direct access to all six repeat rates, to both settings of the day/date select and to an unlisted mask pattern. They also let the bench set bit 6 of the hours alarm byte to show that the 6-bit hours compare ignores it. Tick-less idle cycles, clearing in the same cycle as a match and toggling the enables show the flag and output timing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  typedef enum logic [2:0] {
    RATE_EVERY = 3'd0,
    RATE_S     = 3'd1,
    RATE_MS    = 3'd2,
    RATE_HMS   = 3'd3,
    RATE_FULL  = 3'd4
  } rate_e;

  // mask order {am4, am3, am2, am1}; unlisted patterns fall back to every-second
  function automatic rate_e decode_rate(input logic [3:0] m);
    case (m)
      4'b1110: decode_rate = RATE_S;
      4'b1100: decode_rate = RATE_MS;
      4'b1000: decode_rate = RATE_HMS;
      4'b0000: decode_rate = RATE_FULL;
      default: decode_rate = RATE_EVERY;
    endcase
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_ALM = 4,
  parameter logic [ADDR_W-1:0] ALM_BASE = 4'h8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hC
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [NUM_ALM-1:0][DATA_W-1:0]  alm_o,
  output logic                            te_o,
  output logic                            tie_o,
  output logic                            tpe_o
);

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    localparam logic [ADDR_W-1:0] MyAddr = ADDR_W'(ALM_BASE + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              alm_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == MyAddr)  alm_o[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_o  <= 1'b0;
      tie_o <= 1'b0;
      tpe_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
      te_o  <= wr_data_i[0];
      tie_o <= wr_data_i[1];
      tpe_o <= wr_data_i[2];
    end
  end

endmodule

// File: rtl/field_cmp.sv
module field_cmp #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] alm_i,
  input  logic [W-1:0] now_i,
  output logic         eq_o
);
  assign eq_o = (alm_i == now_i);
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEC_W  = 7,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAY_W  = 6
) (
  input  logic [3:0][DATA_W-1:0] alm_i,
  input  logic [SEC_W-1:0]       sec_i,
  input  logic [MIN_W-1:0]       min_i,
  input  logic [HOUR_W-1:0]      hour_i,
  input  logic [DAY_W-1:0]       wday_i,
  input  logic [DAY_W-1:0]       date_i,
  output logic                   hit_o
);
  localparam int unsigned MaskBit = DATA_W - 1;
  localparam int unsigned SelBit  = DATA_W - 2;

  logic [3:0]       mask;
  logic             s_eq, m_eq, h_eq, d_eq;
  logic [DAY_W-1:0] dd_now;
  rate_e            rate;

  for (genvar i = 0; i < 4; i++) begin : g_mask
    assign mask[i] = alm_i[i][MaskBit];
  end

  assign dd_now = alm_i[3][SelBit] ? wday_i : date_i;
  assign rate   = decode_rate(mask);

  field_cmp #(.W(SEC_W))  u_sec  (.alm_i(alm_i[0][SEC_W-1:0]),  .now_i(sec_i),  .eq_o(s_eq));
  field_cmp #(.W(MIN_W))  u_min  (.alm_i(alm_i[1][MIN_W-1:0]),  .now_i(min_i),  .eq_o(m_eq));
  field_cmp #(.W(HOUR_W)) u_hour (.alm_i(alm_i[2][HOUR_W-1:0]), .now_i(hour_i), .eq_o(h_eq));
  field_cmp #(.W(DAY_W))  u_day  (.alm_i(alm_i[3][DAY_W-1:0]),  .now_i(dd_now), .eq_o(d_eq));

  always_comb begin
    case (rate)
      RATE_S:    hit_o = s_eq;
      RATE_MS:   hit_o = s_eq & m_eq;
      RATE_HMS:  hit_o = s_eq & m_eq & h_eq;
      RATE_FULL: hit_o = s_eq & m_eq & h_eq & d_eq;
      default:   hit_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic tie_i,
  input  logic tpe_i,
  output logic flag_o,
  output logic irq_no,
  output logic pwr_no
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over a same-cycle clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assign irq_no = ~(flag_o & tie_i);
  assign pwr_no = ~(flag_o & tpe_i);

  AST_FLAG_ROSE_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));  // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);  // R7
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);  // R7
  AST_OUTS_FALL_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> (irq_no && pwr_no));  // R8

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEC_W  = 7,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DAY_W  = 6,
  parameter logic [ADDR_W-1:0] ALM_BASE  = 4'h8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HOUR_W-1:0] hour_i,
  input  logic [DAY_W-1:0]  wday_i,
  input  logic [DAY_W-1:0]  date_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_no,
  output logic              pwr_no
);
  localparam int unsigned NumAlm = 4;

  logic [NumAlm-1:0][DATA_W-1:0] alm;
  logic te, tie, tpe, hit, set;

  alarm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ALM(NumAlm),
    .ALM_BASE(ALM_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .alm_o(alm), .te_o(te), .tie_o(tie), .tpe_o(tpe)
  );

  alarm_cmp #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)
  ) u_cmp (
    .alm_i(alm), .sec_i, .min_i, .hour_i, .wday_i, .date_i, .hit_o(hit)
  );

  assign set = tick_i & te & hit;

  alarm_flag u_flag (
    .clk_i, .rst_ni, .set_i(set), .clr_i,
    .tie_i(tie), .tpe_i(tpe),
    .flag_o, .irq_no, .pwr_no
  );

  AST_NO_SET_WITHOUT_TE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te && !flag_o) |=> !flag_o);  // R6
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_o) |=> !flag_o);  // R7
  AST_ALL_MASKED_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && te && alm[0][DATA_W-1] && alm[1][DATA_W-1] && alm[2][DATA_W-1]
     && alm[3][DATA_W-1]) |=> flag_o);  // R2

endmodule

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [6:0] sec = '0;
  logic [6:0] mins = '0;
  logic [5:0] hour = '0;
  logic [5:0] wday = '0;
  logic [5:0] date = '0;
  logic       clr = 1'b0;
  logic       flag, irq_n, pwr_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .sec_i(sec), .min_i(mins),
    .hour_i(hour), .wday_i(wday), .date_i(date), .clr_i(clr),
    .flag_o(flag), .irq_no(irq_n), .pwr_no(pwr_n)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] dd);
    wr(4'h8, s); wr(4'h9, m); wr(4'hA, h); wr(4'hB, dd);
  endtask

  // tick with the given time; flag sampled at the following negedge
  task automatic tick_at(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] wd, input logic [5:0] dt, input logic with_clr);
    @(negedge clk);
    sec = s; mins = m; hour = h; wday = wd; date = dt; tick = 1'b1; clr = with_clr;
    @(negedge clk);
    tick = 1'b0; clr = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R9", "flag after reset", flag, 1'b0);
    check("R9", "irq_n after reset", irq_n, 1'b1);
    check("R9", "pwr_n after reset", pwr_n, 1'b1);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    tick_at(7'h00, 7'h00, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R9", "TE cleared by reset blocks set", flag, 1'b0);
  endtask

  task automatic t_every_second();
    wr(4'hC, 8'h01);
    tick_at(7'h12, 7'h34, 6'h05, 6'h2, 6'h11, 1'b0);
    check("R2", "1111 fires on tick", flag, 1'b1);
    do_clr();
    check("R7", "clear drops flag", flag, 1'b0);
    tick_at(7'h59, 7'h59, 6'h23, 6'h7, 6'h31, 1'b0);
    check("R2", "1111 fires on second tick", flag, 1'b1);
    do_clr();
  endtask

  task automatic t_partial_rates();
    set_alarm(8'h30, 8'hC5, 8'hD2, 8'h80);  // 1110
    tick_at(7'h31, 7'h00, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R3", "1110 seconds mismatch", flag, 1'b0);
    tick_at(7'h30, 7'h11, 6'h09, 6'h1, 6'h1, 1'b0);
    check("R3", "1110 seconds match", flag, 1'b1);
    do_clr();
    wr(4'h9, 8'h45);                         // 1100
    tick_at(7'h30, 7'h44, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R3", "1100 minutes mismatch", flag, 1'b0);
    tick_at(7'h30, 7'h45, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R3", "1100 match", flag, 1'b1);
    do_clr();
    wr(4'hA, 8'h52);                         // 1000, hour 12 with bit 6 set
    tick_at(7'h30, 7'h45, 6'h13, 6'h1, 6'h1, 1'b0);
    check("R3", "1000 hours mismatch", flag, 1'b0);
    tick_at(7'h30, 7'h45, 6'h12, 6'h1, 6'h1, 1'b0);
    check("R10", "1000 match, hour byte bit 6 ignored", flag, 1'b1);
    do_clr();
  endtask

  task automatic t_day_date();
    wr(4'hB, 8'h15);                         // 0000, date 15
    tick_at(7'h30, 7'h45, 6'h12, 6'h03, 6'h15, 1'b0);
    check("R4", "date match", flag, 1'b1);
    do_clr();
    tick_at(7'h30, 7'h45, 6'h12, 6'h15, 6'h16, 1'b0);
    check("R4", "date mismatch ignores wday", flag, 1'b0);
    wr(4'hB, 8'h43);                         // day select, day 3
    tick_at(7'h30, 7'h45, 6'h12, 6'h03, 6'h20, 1'b0);
    check("R4", "wday match", flag, 1'b1);
    do_clr();
    tick_at(7'h30, 7'h45, 6'h12, 6'h04, 6'h03, 1'b0);
    check("R4", "wday mismatch ignores date", flag, 1'b0);
  endtask

  task automatic t_illegal_mask();
    set_alarm(8'hB0, 8'h45, 8'h92, 8'h15);   // 0101
    tick_at(7'h01, 7'h02, 6'h03, 6'h04, 6'h05, 1'b0);
    check("R5", "0101 fires every tick", flag, 1'b1);
    do_clr();
    set_alarm(8'h30, 8'hC5, 8'h12, 8'h95);   // 1010
    tick_at(7'h01, 7'h02, 6'h03, 6'h04, 6'h05, 1'b0);
    check("R5", "1010 fires every tick", flag, 1'b1);
    do_clr();
  endtask

  task automatic t_te_gate();
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    wr(4'hC, 8'h06);
    tick_at(7'h00, 7'h00, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R6", "TE=0 blocks set", flag, 1'b0);
    check("R6", "TE=0 irq_n stays high", irq_n, 1'b1);
    wr(4'hC, 8'h01);
  endtask

  task automatic t_tick_and_clear();
    repeat (6) @(negedge clk);
    check("R7", "no tick, no set", flag, 1'b0);
    tick_at(7'h00, 7'h00, 6'h00, 6'h1, 6'h1, 1'b0);
    repeat (4) @(negedge clk);
    check("R7", "flag sticky without clear", flag, 1'b1);
    do_clr();
    tick_at(7'h00, 7'h00, 6'h00, 6'h1, 6'h1, 1'b1);
    check("R7", "set and clear same cycle keeps flag", flag, 1'b1);
    do_clr();
    check("R7", "later clear drops flag", flag, 1'b0);
  endtask

  task automatic t_outputs();
    wr(4'hC, 8'h03);
    tick_at(7'h00, 7'h00, 6'h00, 6'h1, 6'h1, 1'b0);
    check("R8", "irq_n low with TIE", irq_n, 1'b0);
    check("R8", "pwr_n high without TPE", pwr_n, 1'b1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'hC; wr_data = 8'h05;
    @(negedge clk); wr_en = 1'b0;
    check("R8", "irq_n rises after TIE off", irq_n, 1'b1);
    check("R8", "pwr_n low with TPE", pwr_n, 1'b0);
    check("R1", "control write keeps flag", flag, 1'b1);
    wr(4'hC, 8'h07);
    check("R8", "irq_n low both enables", irq_n, 1'b0);
    do_clr();
    check("R8", "irq_n high after clear", irq_n, 1'b1);
    check("R8", "pwr_n high after clear", pwr_n, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_every_second();
    t_partial_rates();
    t_day_date();
    t_illegal_mask();
    t_te_gate();
    t_tick_and_clear();
    t_outputs();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule